// File: doc/BRIEF.md
# Snoop Control Register Block

This block is the software-visible register face of a multi-core cluster's snoop control unit. It decodes a 256-byte window on a simple 32-bit register bus with read and write strobes, and holds a single enable bit that software sets to turn snooping on. It also answers with a read-only configuration word built from the core-count parameter. The enable bit is driven out on `snoop_en`.

A handful of other offsets are defined but inert. The secure-state invalidate-all location accepts writes and does nothing, because no caches are modelled. The two address-filter locations read zero and drop writes, as a cluster with one bus master would. Every remaining offset is treated as unimplemented. It reads zero, drops writes and raises a one-cycle error pulse, so that a bench or a bus wrapper can flag the stray access. Read data is registered and appears one clock after the read strobe.

Top module: `scu_reg_block`

## Requirements
- R1: After reset, `snoop_en`, `bus_rdata` and `bus_err` are all zero.
- R2: A write to byte offset 0x00 stores `bus_wdata[0]` in the enable bit, which drives `snoop_en`. A read of 0x00 returns the enable bit in bit 0, with bits 31..1 zero.
- R3: A read of byte offset 0x04 returns `(((1 << N) - 1) << 4) | (N - 1)`, where N is `NUM_CORES` (1 to 4). This places a core-presence mask at bit 4 upward and the count minus one in the low bits. A write to 0x04 changes neither `snoop_en` nor that value.
- R4: A write to byte offset 0x0C is accepted, raises no error and leaves `snoop_en` unchanged. A read of 0x0C returns zero.
- R5: Byte offsets 0x40 and 0x44 read as zero, ignore writes (`snoop_en` unchanged) and raise no error.
- R6: Byte offsets 0x08, 0x50 and 0x54, and every offset not named in R2 to R5, read as zero and ignore writes.
- R7: `bus_err` is high for exactly the one cycle after a read or write strobe to an offset covered by R6. It is low after any other access and after a cycle with no strobe.
- R8: `bus_rdata` holds the read result in the cycle after `bus_rd`. It is zero in the cycle after a cycle without `bus_rd`.
- R9: Address bits 1..0 are ignored. Decoding uses only `bus_addr[7:2]`, the word index.
- R10: When `bus_rd` and `bus_wr` both target offset 0x00 in the same cycle, the read returns the enable bit as it stood before that write, and the write then takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 8 | Byte offset within the 256-byte window |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle pulse flagging an unimplemented offset |
| snoop_en | output | 1 | Current value of the enable bit |

## Verification
The bench builds four copies of the block side by side, with `NUM_CORES` set to 1, 2, 3 and 4, and drives all of them from one shared bus. This puts every configuration word the parameter range allows under check in a single run. Each copy is swept over all 64 word indices with two write patterns and a rotating choice of the ignored low address bits. That sweep reaches every defined, inert and unimplemented offset, and shows that no stray write disturbs the enable bit. Directed steps then cover the same-cycle read-and-write case and the idle cycle that follows a read.

// File: rtl/scu_reg_pkg.sv
package scu_reg_pkg;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int WIDX_W = ADDR_W - 2;

  typedef enum logic [2:0] {
    SEL_CTRL,
    SEL_CFG,
    SEL_INVAL,
    SEL_FILT,
    SEL_UNIMPL
  } reg_sel_e;

  localparam logic [WIDX_W-1:0] IDX_CTRL    = 6'h00;
  localparam logic [WIDX_W-1:0] IDX_CFG     = 6'h01;
  localparam logic [WIDX_W-1:0] IDX_INVAL   = 6'h03;
  localparam logic [WIDX_W-1:0] IDX_FILT_LO = 6'h10;
  localparam logic [WIDX_W-1:0] IDX_FILT_HI = 6'h11;

  // Word index to register selection; anything unlisted is unimplemented.
  function automatic reg_sel_e decode_word(logic [WIDX_W-1:0] idx);
    reg_sel_e s;
    case (idx)
      IDX_CTRL:    s = SEL_CTRL;
      IDX_CFG:     s = SEL_CFG;
      IDX_INVAL:   s = SEL_INVAL;
      IDX_FILT_LO: s = SEL_FILT;
      IDX_FILT_HI: s = SEL_FILT;
      default:     s = SEL_UNIMPL;
    endcase
    return s;
  endfunction

  // Presence mask at bit 4 upward, core count minus one below it.
  function automatic logic [DATA_W-1:0] cfg_word(int unsigned n);
    logic [DATA_W-1:0] mask;
    mask = (DATA_W'(1) << n) - DATA_W'(1);
    return (mask << 4) | DATA_W'(n - 1);
  endfunction

endpackage

// File: rtl/scu_addr_decode.sv
module scu_addr_decode
  import scu_reg_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic              unimpl_hit
);
  logic unused_lsb;
  assign unused_lsb = ^addr[1:0];

  assign sel        = decode_word(addr[ADDR_W-1:2]);
  assign unimpl_hit = (sel == SEL_UNIMPL);
endmodule

// File: rtl/scu_ctrl_reg.sv
module scu_ctrl_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q <= 1'b0;
    else if (wr_en) q <= d;
  end
endmodule

// File: rtl/scu_read_port.sv
module scu_read_port
  import scu_reg_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic              wr,
  input  reg_sel_e          sel,
  input  logic              unimpl_hit,
  input  logic              ctrl_q,
  output logic [DATA_W-1:0] rdata,
  output logic              err
);
  localparam logic [DATA_W-1:0] CFG_VALUE = cfg_word(NUM_CORES);

  logic [DATA_W-1:0] rd_value;

  always_comb begin
    case (sel)
      SEL_CTRL: rd_value = {{(DATA_W-1){1'b0}}, ctrl_q};
      SEL_CFG:  rd_value = CFG_VALUE;
      default:  rd_value = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
      err   <= 1'b0;
    end else begin
      rdata <= rd ? rd_value : '0;
      err   <= (rd | wr) & unimpl_hit;
    end
  end
endmodule

// File: rtl/scu_reg_block.sv
module scu_reg_block
  import scu_reg_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  output logic              snoop_en
);
  reg_sel_e sel;
  logic     unimpl_hit;
  logic     ctrl_wr_hit;
  logic     unused_wdata;

  assign unused_wdata = ^bus_wdata[DATA_W-1:1];

  scu_addr_decode u_decode (
    .addr       (bus_addr),
    .sel        (sel),
    .unimpl_hit (unimpl_hit)
  );

  assign ctrl_wr_hit = bus_wr && (sel == SEL_CTRL);

  scu_ctrl_reg u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (ctrl_wr_hit),
    .d     (bus_wdata[0]),
    .q     (snoop_en)
  );

  scu_read_port #(.NUM_CORES(NUM_CORES)) u_read (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd         (bus_rd),
    .wr         (bus_wr),
    .sel        (sel),
    .unimpl_hit (unimpl_hit),
    .ctrl_q     (snoop_en),
    .rdata      (bus_rdata),
    .err        (bus_err)
  );
endmodule

// File: rtl/scu_reg_block_chk.sv
module scu_reg_block_chk
  import scu_reg_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_err,
  input logic              snoop_en,
  input logic              unimpl_hit
);
  localparam logic [DATA_W-1:0] EXP_CFG =
    DATA_W'((((1 << NUM_CORES) - 1) * 16) + NUM_CORES - 1);

  logic [WIDX_W-1:0] widx;
  logic              unused_chk;
  assign widx       = bus_addr[ADDR_W-1:2];
  assign unused_chk = ^{bus_wdata[DATA_W-1:1], bus_addr[1:0]};

  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && widx == 6'h00) |=> (snoop_en == $past(bus_wdata[0]))); // R2
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && widx == 6'h00) |=> $stable(snoop_en)); // R3
  AST_CTRL_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && widx == 6'h00) |=> (bus_rdata == {31'b0, $past(snoop_en)})); // R10
  AST_CFG_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && widx == 6'h01) |=> (bus_rdata == EXP_CFG)); // R3
  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && unimpl_hit) |=> (bus_rdata == '0)); // R6
  AST_ERR_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rd || bus_wr) && unimpl_hit) |=> bus_err); // R7
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !((bus_rd || bus_wr) && unimpl_hit) |=> !bus_err); // R7
  AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> (bus_rdata == '0)); // R8
endmodule

bind scu_reg_block scu_reg_block_chk #(.NUM_CORES(NUM_CORES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_rd     (bus_rd),
  .bus_wr     (bus_wr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .bus_err    (bus_err),
  .snoop_en   (snoop_en),
  .unimpl_hit (unimpl_hit)
);

// File: tb/scu_reg_block_bench.sv
module scu_reg_block_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;

  logic [31:0] rdata_a [1:4];
  logic        err_a   [1:4];
  logic        en_a    [1:4];

  int checks = 0;
  int failures = 0;
  logic en_model = 1'b0;

  always #5 clk = ~clk;

  for (genvar g = 1; g <= 4; g++) begin : gen_core
    scu_reg_block #(.NUM_CORES(g)) u_scu_reg_block (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_rd    (bus_rd),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (rdata_a[g]),
      .bus_err   (err_a[g]),
      .snoop_en  (en_a[g])
    );
  end

  function automatic logic [31:0] exp_cfg(int n);
    return 32'((2 ** n - 1) * 16 + n - 1);
  endfunction

  function automatic bit is_unimpl(int w);
    return !(w == 0 || w == 1 || w == 3 || w == 16 || w == 17);
  endfunction

  task automatic chk(string tag, int core, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s core=%0d actual=%h expected=%h", tag, core, act, exp);
    end
  endtask

  task automatic access(logic rd, logic wr, logic [7:0] addr, logic [31:0] wd);
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_addr = addr; bus_wdata = wd;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int c = 1; c <= 4; c++) begin
      chk("R1 enable", c, {31'b0, en_a[c]}, 32'd0);
      chk("R1 rdata", c, rdata_a[c], 32'd0);
      chk("R1 err", c, {31'b0, err_a[c]}, 32'd0);
    end

    access(1'b0, 1'b1, 8'h00, 32'h0000_0001);
    en_model = 1'b1;
    for (int c = 1; c <= 4; c++)
      chk("R2 set enable", c, {31'b0, en_a[c]}, 32'd1);

    for (int pass = 0; pass < 2; pass++) begin
      for (int w = 0; w < 64; w++) begin
        logic [31:0] pat;
        logic [7:0]  a;
        pat = (pass == 0) ? 32'hFFFF_FFFF : 32'h5A5A_5A5A;
        a   = {w[5:0], 2'(w + pass)};   // R9: low bits vary
        if (w == 0) begin
          pat = (pass == 0) ? 32'hFFFF_FFFE : 32'hA5A5_A5A5;
          en_model = pat[0];
        end
        access(1'b0, 1'b1, a, pat);
        for (int c = 1; c <= 4; c++) begin
          chk(w == 0 ? "R2 write" : (w == 1 ? "R3 write ignored" :
              (w == 3 ? "R4 invalidate no-op" : (w == 16 || w == 17 ?
              "R5 filter write" : "R6 write ignored"))),
              c, {31'b0, en_a[c]}, {31'b0, en_model});
          chk("R7 write err", c, {31'b0, err_a[c]}, {31'b0, is_unimpl(w)});
        end
        access(1'b1, 1'b0, a, 32'h0);
        for (int c = 1; c <= 4; c++) begin
          logic [31:0] e;
          e = (w == 0) ? {31'b0, en_model} : ((w == 1) ? exp_cfg(c) : 32'd0);
          chk(w == 1 ? "R3 config read" : (w == 0 ? "R2 read" :
              "R6 read zero R9"), c, rdata_a[c], e);
          chk("R7 read err", c, {31'b0, err_a[c]}, {31'b0, is_unimpl(w)});
        end
      end
    end

    access(1'b0, 1'b1, 8'h00, 32'h1);
    en_model = 1'b1;
    access(1'b1, 1'b1, 8'h00, 32'h0);
    en_model = 1'b0;
    for (int c = 1; c <= 4; c++) begin
      chk("R10 read old value", c, rdata_a[c], 32'd1);
      chk("R10 write applied", c, {31'b0, en_a[c]}, 32'd0);
    end

    access(1'b1, 1'b0, 8'h04, 32'h0);
    @(negedge clk);
    for (int c = 1; c <= 4; c++) begin
      chk("R8 idle rdata", c, rdata_a[c], 32'd0);
      chk("R7 idle err", c, {31'b0, err_a[c]}, 32'd0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule